// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This block adds or subtracts two numbers held in signed-magnitude form. Each operand is one sign bit (1 means negative) and a `W`-bit magnitude. A single-cycle `start` strobe loads both operands and the operation select. A short fixed sequence of controller states then works the result out in place, in an accumulator magnitude register. All magnitude arithmetic, both the sum and any recomplement, goes through one shared ripple-carry adder. Subtraction is done by feeding it the inverted operand with a carry-in of one.

The controller has five states. `ST_IDLE` waits for `start`, and the edge that accepts it loads the registers. `ST_SUM` adds the magnitudes or forms the difference, and the adder's carry goes into a carry flag. `ST_FIX` two's-complements the accumulator and flips its sign when a difference produced no carry. `ST_ZERO` forces a zero difference positive. `ST_DONE` raises `done` for one cycle and then returns to `ST_IDLE`. The transitions are fixed: IDLE→SUM on an accepted start, then SUM→FIX, FIX→ZERO, ZERO→DONE and DONE→IDLE unconditionally. The result ports hold their value until the next accepted start.

Top module: `sm_addsub`

## Requirements
- R1: After reset, `done`, `ovf`, `res_sign` and `res_mag` are all 0.
- R2: `start` is accepted only in `ST_IDLE`. `done` is then high for exactly one cycle, beginning at the third rising edge after the accepting edge.
- R3: `start` has no effect from the accepting edge until `ST_IDLE` is reached again, and operand inputs changed in that interval do not alter the result.
- R4: The effective sign of B is `b_sign` XOR `op_sub` (`op_sub`=1 selects subtract, 0 selects add).
- R5: When `a_sign` equals the effective sign of B, `res_mag` is (`a_mag`+`b_mag`) mod 2^W and `res_sign` is `a_sign`.
- R6: `ovf` is 1 exactly when the signs are equal and `a_mag`+`b_mag` ≥ 2^W; a difference never sets it.
- R7: When the signs differ and `a_mag` > `b_mag`, `res_mag` is `a_mag`−`b_mag` and `res_sign` is `a_sign`.
- R8: When the signs differ and `a_mag` < `b_mag`, `res_mag` is `b_mag`−`a_mag` and `res_sign` is the inverse of `a_sign`.
- R9: When the signs differ and the magnitudes are equal, the result is magnitude 0 with `res_sign` 0.
- R10: `res_sign`, `res_mag` and `ovf` stay unchanged from the `done` cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op_sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_mag | input | W | Magnitude of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_mag | input | W | Magnitude of operand B |
| res_sign | output | 1 | Sign of the result |
| res_mag | output | W | Magnitude of the result |
| ovf | output | 1 | Magnitude overflow of a same-sign sum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with `W` = 4. This makes the full operand space small enough to cover: every sign pair, every magnitude pair and both operations, 2048 cases in all. The sweep reaches every carry-out overflow, every equal-magnitude difference that must come out as positive zero, and both recomplement outcomes. During every operation the bench also pulses `start` again and scrambles the operand inputs, to show they are ignored while the unit is busy.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SUM  = 3'd1,
        ST_FIX  = 3'd2,
        ST_ZERO = 3'd3,
        ST_DONE = 3'd4
    } sm_state_t;

    typedef struct packed {
        logic load;
        logic sum_en;
        logic fix_en;
        logic zero_en;
    } sm_ctl_t;

endpackage

// File: rtl/sm_addsub_adder.sv
module sm_addsub_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign cout = carry[W];
endmodule

// File: rtl/sm_addsub_ctrl.sv
module sm_addsub_ctrl
    import sm_addsub_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    diff,
    input  logic    e_flag,
    input  logic    a_zero,
    output sm_ctl_t ctl,
    output logic    done
);
    sm_state_t state_q;
    sm_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SUM;
            ST_SUM:  state_d = ST_FIX;
            ST_FIX:  state_d = ST_ZERO;
            ST_ZERO: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl  = '0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ctl.load    = start;
            ST_SUM:  ctl.sum_en  = 1'b1;
            ST_FIX:  ctl.fix_en  = diff & ~e_flag;
            ST_ZERO: ctl.zero_en = diff & a_zero;
            ST_DONE: done        = 1'b1;
            default: begin
                ctl  = '0;
                done = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sm_addsub_dp.sv
module sm_addsub_dp
    import sm_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sm_ctl_t      ctl,
    input  logic         op_sub,
    input  logic         a_sign,
    input  logic [W-1:0] a_mag,
    input  logic         b_sign,
    input  logic [W-1:0] b_mag,
    output logic         diff,
    output logic         e_flag,
    output logic         a_zero,
    output logic         res_sign,
    output logic [W-1:0] res_mag,
    output logic         ovf
);
    logic [W-1:0] acc_q;
    logic [W-1:0] opb_q;
    logic         as_q;
    logic         diff_q;
    logic         e_q;
    logic         v_q;

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;

    // One adder serves both steps: A +/- B in the sum step, ~A + 1 in the fix step.
    always_comb begin
        if (ctl.fix_en) begin
            add_x   = ~acc_q;
            add_y   = '0;
            add_cin = 1'b1;
        end else begin
            add_x   = acc_q;
            add_y   = diff_q ? ~opb_q : opb_q;
            add_cin = diff_q;
        end
    end

    sm_addsub_adder #(.W(W)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            opb_q  <= '0;
            as_q   <= 1'b0;
            diff_q <= 1'b0;
            e_q    <= 1'b0;
            v_q    <= 1'b0;
        end else if (ctl.load) begin
            acc_q  <= a_mag;
            opb_q  <= b_mag;
            as_q   <= a_sign;
            diff_q <= a_sign ^ (b_sign ^ op_sub);
            e_q    <= 1'b0;
            v_q    <= 1'b0;
        end else if (ctl.sum_en) begin
            acc_q  <= add_sum;
            e_q    <= add_cout;
            v_q    <= add_cout & ~diff_q;
        end else if (ctl.fix_en) begin
            acc_q  <= add_sum;
            as_q   <= ~as_q;
        end else if (ctl.zero_en) begin
            as_q   <= 1'b0;
        end
    end

    assign diff     = diff_q;
    assign e_flag   = e_q;
    assign a_zero   = (acc_q == '0);
    assign res_sign = as_q;
    assign res_mag  = acc_q;
    assign ovf      = v_q;
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sub,
    input  logic         a_sign,
    input  logic [W-1:0] a_mag,
    input  logic         b_sign,
    input  logic [W-1:0] b_mag,
    output logic         res_sign,
    output logic [W-1:0] res_mag,
    output logic         ovf,
    output logic         done
);
    sm_ctl_t ctl;
    logic    diff;
    logic    e_flag;
    logic    a_zero;

    sm_addsub_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .diff   (diff),
        .e_flag (e_flag),
        .a_zero (a_zero),
        .ctl    (ctl),
        .done   (done)
    );

    sm_addsub_dp #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .op_sub   (op_sub),
        .a_sign   (a_sign),
        .a_mag    (a_mag),
        .b_sign   (b_sign),
        .b_mag    (b_mag),
        .diff     (diff),
        .e_flag   (e_flag),
        .a_zero   (a_zero),
        .res_sign (res_sign),
        .res_mag  (res_mag),
        .ovf      (ovf)
    );
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op_sub,
    input logic         a_sign,
    input logic         b_sign,
    input logic         res_sign,
    input logic [W-1:0] res_mag,
    input logic         ovf,
    input logic         done
);
    logic       busy_q;
    logic [2:0] cnt_q;
    logic       diff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            diff_q <= 1'b0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            cnt_q  <= 3'd1;
            diff_q <= a_sign ^ b_sign ^ op_sub;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            else      cnt_q  <= cnt_q + 3'd1;
        end
    end

    // R2: done arrives only after the full sequence
    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_q && cnt_q == 3'd4));

    // R2: done lasts a single cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a difference never reports overflow
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && diff_q) |-> !ovf);

    // R9: zero difference is positive
    p_pos_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && diff_q && res_mag == '0) |-> !res_sign);

    // R10: result holds after completion
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(res_mag) && $stable(res_sign) && $stable(ovf)));
endmodule

bind sm_addsub sm_addsub_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_sub   (op_sub),
    .a_sign   (a_sign),
    .b_sign   (b_sign),
    .res_sign (res_sign),
    .res_mag  (res_mag),
    .ovf      (ovf),
    .done     (done)
);

// File: tb/sm_addsub_test.sv
`timescale 1ns/1ps
module sm_addsub_test;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic         a_sign = 1'b0;
    logic [W-1:0] a_mag = '0;
    logic         b_sign = 1'b0;
    logic [W-1:0] b_mag = '0;
    logic         res_sign;
    logic [W-1:0] res_mag;
    logic         ovf;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sm_addsub #(.W(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_sub   (op_sub),
        .a_sign   (a_sign),
        .a_mag    (a_mag),
        .b_sign   (b_sign),
        .b_mag    (b_mag),
        .res_sign (res_sign),
        .res_mag  (res_mag),
        .ovf      (ovf),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int op, input int as, input int bs,
                            input int a, input int b);
        int eb_sign;
        int e_mag;
        int e_sign;
        int e_ovf;
        string req;
        eb_sign = bs ^ op;                       // R4
        if (as == eb_sign) begin
            e_mag  = (a + b) % M;                // R5
            e_sign = as;
            e_ovf  = ((a + b) >= M) ? 1 : 0;     // R6
            req    = e_ovf ? "R6" : "R5";
        end else if (a > b) begin
            e_mag = a - b; e_sign = as; e_ovf = 0; req = "R7";
        end else if (a < b) begin
            e_mag = b - a; e_sign = 1 - as; e_ovf = 0; req = "R8";
        end else begin
            e_mag = 0; e_sign = 0; e_ovf = 0; req = "R9";
        end

        @(negedge clk);
        op_sub = op[0]; a_sign = as[0]; b_sign = bs[0];
        a_mag = a[W-1:0]; b_mag = b[W-1:0];
        start = 1'b1;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            // R3: scramble inputs and re-pulse start while busy
            start  = (n == 2 || n == 3);
            a_mag  = ~a_mag;
            b_mag  = b_mag + 1'b1;
            a_sign = ~a_sign;
            op_sub = ~op_sub;
            if (n < 4)
                check(done == 1'b0, "R2", "early done", done, 0);
            else
                check(done == 1'b1, "R2", "done timing", done, 1);
        end
        start = 1'b0;
        check(res_mag == e_mag[W-1:0], req, "magnitude", res_mag, e_mag);
        check(res_sign == e_sign[0], req, "sign", res_sign, e_sign);
        check(ovf == e_ovf[0], "R6", "overflow", ovf, e_ovf);
        @(negedge clk);
        check(done == 1'b0, "R3", "no second done", done, 0);
        check(res_mag == e_mag[W-1:0] && res_sign == e_sign[0] && ovf == e_ovf[0],
              "R10", "hold", {ovf, res_sign, res_mag}, {e_ovf[0], e_sign[0], e_mag[W-1:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && ovf == 1'b0 && res_sign == 1'b0 && res_mag == '0,
              "R1", "reset outputs", {done, ovf, res_sign, res_mag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int op = 0; op < 2; op++)
            for (int as = 0; as < 2; as++)
                for (int bs = 0; bs < 2; bs++)
                    for (int a = 0; a < M; a++)
                        for (int b = 0; b < M; b++)
                            run_case(op, as, bs, a, b);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule